// File: doc/BRIEF.md
# Incremental PID Controller with Compare-Range Limiter

This block turns a setpoint and a measured speed into a compare value for a downstream pulse-width stage. It works in velocity form: instead of summing errors over all time, it computes only the change of the control value on each step and adds that change to the value it produced last time. Three gains, supplied by an external tuning stage, may change on every step, and each is applied as it stands in the cycle of that step.

A step is requested by a one-cycle enable. In that cycle the block subtracts the measured value from the setpoint to form the current error. It forms the proportional, integral and derivative terms from the current error and the two previous errors, adds them into an increment and adds the increment to the stored output. The sum is clamped into the legal compare range. At the same clock edge, the clamped value becomes the new output and the error history moves on by one place. A valid pulse marks the cycle in which the new value is first visible.

Without an enable, the block ignores its inputs and holds its output. The clamped value, not the raw sum, is what the next step builds on. As a result the stored output never winds up past the limits.

Top module: `pid_incr_core`

## Requirements
- R1: After reset `ctrl_out` is 0, `out_valid` is 0 and both stored past errors are 0.
- R2: The error of a step is `setpoint - measured`, with both inputs read as signed 16-bit two's-complement values.
- R3: Only two past errors are kept. At each enabled step, the previous error e(k-1) takes the current error, and e(k-2) takes the old e(k-1).
- R4: The increment is floor(Kp*(e(k)-e(k-1))/256) + floor(Ki*e(k)/256) + floor(Kd*(e(k)-2e(k-1)+e(k-2))/256). Each gain is an unsigned 10-bit value with 8 fraction bits, and each term is rounded toward minus infinity before the terms are summed.
- R5: The new output is the stored output plus the increment, after clamping. The clamped value is stored for the next step.
- R6: A sum above OUT_MAX (default 4999) gives exactly OUT_MAX. `ctrl_out` never exceeds OUT_MAX.
- R7: A negative sum gives exactly 0.
- R8: The new output appears at the rising edge where `step_en` is sampled high. `out_valid` is high for exactly the following cycle, once for each enabled cycle, and is low after any cycle without enable.
- R9: In a cycle without `step_en`, changes on `setpoint`, `measured` and the gains have no effect. `ctrl_out` and the error history keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Perform one control step this cycle |
| setpoint | input | 16 | Desired speed, signed |
| measured | input | 16 | Measured speed, signed |
| kp | input | 10 | Proportional gain, unsigned, 8 fraction bits |
| ki | input | 10 | Integral gain, unsigned, 8 fraction bits |
| kd | input | 10 | Derivative gain, unsigned, 8 fraction bits |
| ctrl_out | output | 16 | Clamped compare value, 0 to OUT_MAX |
| out_valid | output | 1 | One-cycle pulse after each enabled step |

## Verification
Two things can happen in the same enabled cycle: saturation at either limit and the shift of the error history. A wrong design might skip the shift when it clamps, or might store the unclamped sum. The bench provokes this by holding a large error across back-to-back enables with unity gains until the output pins at 4999. It then reverses the error until the output pins at 0, and it keeps stepping while the output is at each limit. A behavioural model with integer history and floor division predicts every later value. Any lost shift, or any stored raw sum, shows up as an output mismatch on the steps after the clamp.

// File: rtl/pid_pkg.sv
package pid_pkg;
  // wide signed accumulator: holds any product/sum of the 17-bit error and 10-bit gain
  localparam int ACC_W = 48;
  typedef logic signed [ACC_W-1:0] acc_t;

  // gain * diff, then drop the fraction bits (arithmetic shift = floor)
  function automatic acc_t scaled_term(input acc_t diff, input acc_t gain, input int frac);
    acc_t prod;
    prod = diff * gain;
    return prod >>> frac;
  endfunction

  // second difference e(k) - 2e(k-1) + e(k-2)
  function automatic acc_t second_diff(input acc_t cur, input acc_t p1, input acc_t p2);
    return cur - (p1 <<< 1) + p2;
  endfunction
endpackage

// File: rtl/pid_err_hist.sv
module pid_err_hist #(
  parameter int DATA_W = 16,
  localparam int EW = DATA_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_en,
  input  logic [DATA_W-1:0]    setpoint,
  input  logic [DATA_W-1:0]    measured,
  output logic signed [EW-1:0] err_now,
  output logic signed [EW-1:0] err_p1,
  output logic signed [EW-1:0] err_p2
);
  assign err_now = $signed({setpoint[DATA_W-1], setpoint}) - $signed({measured[DATA_W-1], measured});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_p1 <= '0;
      err_p2 <= '0;
    end else if (step_en) begin
      err_p1 <= err_now;
      err_p2 <= err_p1;
    end
  end

  // R3
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (err_p2 == $past(err_p1)) && (err_p1 == $past(err_now)));
  // R9
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(err_p1) && $stable(err_p2));
endmodule

// File: rtl/pid_terms.sv
module pid_terms
  import pid_pkg::*;
#(
  parameter int EW     = 17,
  parameter int GAIN_W = 10,
  parameter int FRAC   = 8
) (
  input  logic signed [EW-1:0] err_now,
  input  logic signed [EW-1:0] err_p1,
  input  logic signed [EW-1:0] err_p2,
  input  logic [GAIN_W-1:0]    kp,
  input  logic [GAIN_W-1:0]    ki,
  input  logic [GAIN_W-1:0]    kd,
  output acc_t                 incr
);
  acc_t e0, e1, e2, gp, gi, gd;
  acc_t t_p, t_i, t_d;

  assign e0 = acc_t'({{(ACC_W-EW){err_now[EW-1]}}, err_now});
  assign e1 = acc_t'({{(ACC_W-EW){err_p1[EW-1]}}, err_p1});
  assign e2 = acc_t'({{(ACC_W-EW){err_p2[EW-1]}}, err_p2});
  assign gp = acc_t'({{(ACC_W-GAIN_W){1'b0}}, kp});
  assign gi = acc_t'({{(ACC_W-GAIN_W){1'b0}}, ki});
  assign gd = acc_t'({{(ACC_W-GAIN_W){1'b0}}, kd});

  assign t_p  = scaled_term(e0 - e1, gp, FRAC);
  assign t_i  = scaled_term(e0, gi, FRAC);
  assign t_d  = scaled_term(second_diff(e0, e1, e2), gd, FRAC);
  assign incr = t_p + t_i + t_d;
endmodule

// File: rtl/pid_limit.sv
module pid_limit
  import pid_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int OUT_MAX = 4999
) (
  input  acc_t              raw_sum,
  output logic [DATA_W-1:0] clamped,
  output logic              sat_hi,
  output logic              sat_lo
);
  localparam acc_t MAX_A = acc_t'(OUT_MAX);

  assign sat_hi = (raw_sum > MAX_A);
  assign sat_lo = (raw_sum < 0);

  always_comb begin
    if (sat_hi)      clamped = MAX_A[DATA_W-1:0];
    else if (sat_lo) clamped = '0;
    else             clamped = raw_sum[DATA_W-1:0];
  end
endmodule

// File: rtl/pid_incr_core.sv
module pid_incr_core
  import pid_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GAIN_W  = 10,
  parameter int FRAC    = 8,
  parameter int OUT_MAX = 4999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [DATA_W-1:0] setpoint,
  input  logic [DATA_W-1:0] measured,
  input  logic [GAIN_W-1:0] kp,
  input  logic [GAIN_W-1:0] ki,
  input  logic [GAIN_W-1:0] kd,
  output logic [DATA_W-1:0] ctrl_out,
  output logic              out_valid
);
  localparam int EW = DATA_W + 1;

  logic signed [EW-1:0] err_now, err_p1, err_p2;
  acc_t                 incr, prev_out, raw_sum;
  logic [DATA_W-1:0]    next_out;
  logic                 sat_hi, sat_lo;

  pid_err_hist #(.DATA_W(DATA_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .setpoint(setpoint), .measured(measured),
    .err_now(err_now), .err_p1(err_p1), .err_p2(err_p2)
  );

  pid_terms #(.EW(EW), .GAIN_W(GAIN_W), .FRAC(FRAC)) u_terms (
    .err_now(err_now), .err_p1(err_p1), .err_p2(err_p2),
    .kp(kp), .ki(ki), .kd(kd), .incr(incr)
  );

  assign prev_out = acc_t'({{(ACC_W-DATA_W){1'b0}}, ctrl_out});
  assign raw_sum  = prev_out + incr;

  pid_limit #(.DATA_W(DATA_W), .OUT_MAX(OUT_MAX)) u_lim (
    .raw_sum(raw_sum), .clamped(next_out), .sat_hi(sat_hi), .sat_lo(sat_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_out  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= step_en;
      if (step_en) ctrl_out <= next_out;
    end
  end

  // R8
  valid_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> out_valid);
  // R8
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> !out_valid);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(ctrl_out));
  // R6
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_out <= DATA_W'(OUT_MAX));
  // R6
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && sat_hi) |=> ctrl_out == DATA_W'(OUT_MAX));
  // R7
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && sat_lo) |=> ctrl_out == '0);
  // R5
  sat_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sat_hi && sat_lo));
endmodule

// File: tb/test_pid_incr_core.sv
module test_pid_incr_core;
  localparam int CLK_PERIOD = 10;
  localparam longint OMAX = 4999;

  logic clk = 1'b0;
  logic rst_n;
  logic step_en;
  logic [15:0] setpoint, measured, ctrl_out;
  logic [9:0] kp, ki, kd;
  logic out_valid;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  longint m_out = 0, m_p1 = 0, m_p2 = 0;
  longint exp_out = 0;
  bit exp_valid = 0;
  string exp_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pid_incr_core i_pid_incr_core (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .setpoint(setpoint), .measured(measured),
    .kp(kp), .ki(ki), .kd(kd),
    .ctrl_out(ctrl_out), .out_valid(out_valid)
  );

  function automatic longint floor256(longint p);
    if (p >= 0) return p / 256;
    return -((-p + 255) / 256);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: check previous step's result, then drive this cycle's inputs
  task automatic cyc(bit en, int sp, int pv, int gp, int gi, int gd);
    longint e, u;
    @(negedge clk);
    check(longint'(ctrl_out) == exp_out, exp_tag, longint'(ctrl_out), exp_out);
    check(out_valid == exp_valid, "R8 valid", longint'(out_valid), longint'(exp_valid));
    step_en  = en;
    setpoint = 16'(sp);
    measured = 16'(pv);
    kp = 10'(gp); ki = 10'(gi); kd = 10'(gd);
    if (en) begin
      e = longint'($signed(16'(sp))) - longint'($signed(16'(pv)));
      u = m_out + floor256(longint'(gp & 1023) * (e - m_p1))
                + floor256(longint'(gi & 1023) * e)
                + floor256(longint'(gd & 1023) * (e - 2*m_p1 + m_p2));
      if (u > OMAX) begin u = OMAX; exp_tag = "R6 clamp high"; end
      else if (u < 0) begin u = 0; exp_tag = "R7 clamp low"; end
      else exp_tag = "R2,R3,R4,R5 step";
      m_p2 = m_p1; m_p1 = e; m_out = u;
      exp_out = u; exp_valid = 1;
    end else begin
      exp_tag = "R9 idle hold";
      exp_valid = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step_en = 1'b0;
    setpoint = '0; measured = '0; kp = '0; ki = '0; kd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state checked by first cycle
    cyc(0, 0, 0, 0, 0, 0);
    // R4 R5 unity gains, rising toward clamp (3000, 3000, 4000, 4999)
    cyc(1, 1000, 0, 256, 256, 256);
    cyc(1, 1000, 0, 256, 256, 256);
    cyc(1, 1000, 0, 256, 256, 256);
    cyc(1, 1000, 0, 256, 256, 256);
    // R6 keep stepping while pinned; history must still shift
    cyc(1, 1500, 0, 256, 256, 256);
    cyc(1, 1500, 0, 256, 256, 256);
    // R9 inputs wiggle with no enable
    cyc(0, -7000, 9000, 1023, 1023, 1023);
    cyc(0, 12345, -3, 1, 2, 3);
    // R7 drive to zero and stay pinned
    cyc(1, 0, 3000, 256, 256, 256);
    cyc(1, 0, 3000, 256, 256, 256);
    cyc(1, 0, 3000, 256, 256, 256);
    // R4 fractional gains, floor of negative products
    cyc(1, 500, 0, 128, 0, 0);
    cyc(1, 497, 0, 85, 3, 77);
    cyc(1, 0, 3, 128, 85, 200);
    cyc(1, -32768, 32767, 1023, 1023, 1023);
    cyc(1, 32767, -32768, 1023, 1023, 1023);
    // mixed random traffic, back-to-back and sparse enables
    for (int i = 0; i < 400; i++) begin
      automatic bit en = ($urandom_range(0, 3) != 0);
      automatic int sp = $urandom_range(0, 8000) - 2000;
      automatic int pv = $urandom_range(0, 8000) - 2000;
      if (i % 50 < 5) begin sp = $urandom_range(0, 65535); pv = $urandom_range(0, 65535); end
      cyc(en, sp, pv, $urandom_range(0, 1023), $urandom_range(0, 300), $urandom_range(0, 1023));
    end
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule